// File: doc/BRIEF.md
# Priority Interrupt Level Selector

This block decides which interrupt level, if any, the processor core should take next. It merges fifteen level-sensitive external request lines with a 16-bit software interrupt register and two timer-match flags into one pending vector of sixteen levels. It then takes the highest pending level that sits strictly above the core's current priority level and forms a trap-type code from it.

The request is withheld in three cases: interrupts are globally disabled, the core already handles a trap whose type code is numerically larger than the new code, or no pending level is high enough. Decisions are made again every cycle from the present inputs. The request flag and the trap-type code come from registers, so each reflects the inputs seen at the previous clock edge.

Top module: `pil_sel_top`

## Requirements
- R1: While rst_ni is low, irq_req_o is 0 and irq_tt_o is 0, whatever the other inputs are.
- R2: Level L (1..15) is pending when ext_irq_i[L] is 1 or soft_int_i[L] is 1; soft_int_i[0] is the tick-compare bit and contributes nothing.
- R3: When tick_match_i or stick_match_i is 1, level 14 is pending.
- R4: The selected level is the highest pending level strictly greater than pil_i; a pending level equal to or below pil_i never raises a request.
- R5: With a request raised, irq_tt_o equals TT_BASE ORed with the selected level, which with the default TT_BASE of 0x040 is 0x040 + level.
- R6: With tl_i nonzero and svc_tt_i greater than the selected code, no request is raised; with tl_i zero, or svc_tt_i not greater, svc_tt_i has no effect.
- R7: With int_en_i low, irq_req_o is 0 and irq_tt_o is 0; the pending inputs are evaluated again as soon as int_en_i returns high.
- R8: The outputs change only at a clock edge and reflect the inputs sampled at that edge: one cycle of latency.
- R9: Whenever irq_req_o is 0, irq_tt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 15 | External request lines; bit L requests level L (1..15) |
| soft_int_i | input | 16 | Software interrupt register; bit 0 is the tick-compare bit |
| tick_match_i | input | 1 | Tick timer match flag |
| stick_match_i | input | 1 | System tick timer match flag |
| pil_i | input | 4 | Current processor priority level |
| int_en_i | input | 1 | Global interrupt enable |
| tl_i | input | 3 | Current trap level |
| svc_tt_i | input | 9 | Trap type currently in service |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_tt_o | output | 9 | Trap-type code of the request |

## Verification
A wrong scan or merge shows at the ports as a wrong low nibble of irq_tt_o, or a request raised or missed, exactly one cycle after the inputs that expose it. Since nothing but the output registers holds state, every fault becomes visible within that single cycle, and the bench compares each cycle with a value computed from the inputs alone. The sweeps walk every single level against every priority level, both timer flags, the suppression comparison on both sides of its boundary, and random mixed vectors.

// File: rtl/pil_sel_pkg.sv
package pil_sel_pkg;
  localparam int unsigned NUM_LVL = 16;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  localparam int unsigned TT_W    = 9;
  typedef logic [NUM_LVL-1:0] pend_t;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [TT_W-1:0]    tt_t;
endpackage

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned TIMER_LVL = 14,
  parameter logic [NUM_LVL-1:0] SOFT_MASK = 16'h0001
) (
  input  logic [NUM_LVL-1:1] ext_irq_i,
  input  logic [NUM_LVL-1:0] soft_int_i,
  input  logic               tick_hit_i,
  input  logic               stick_hit_i,
  output logic [NUM_LVL-1:0] pend_o
);
  always_comb begin
    pend_o = {ext_irq_i, 1'b0} | (soft_int_i & ~SOFT_MASK);
    if (tick_hit_i || stick_hit_i) pend_o[TIMER_LVL] = 1'b1;
  end
endmodule

// File: rtl/pil_prio_scan.sv
module pil_prio_scan #(
  parameter int unsigned NUM_LVL = 16,
  parameter int unsigned LVL_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [LVL_W-1:0]   pil_i,
  output logic               win_vld_o,
  output logic [LVL_W-1:0]   win_lvl_o
);
  logic [NUM_LVL-1:0] elig;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
    assign elig[g] = pend_i[g] && (LVL_W'(g) > pil_i);
  end

  // ascending walk, last hit is highest level
  always_comb begin
    win_vld_o = 1'b0;
    win_lvl_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (elig[i]) begin
        win_vld_o = 1'b1;
        win_lvl_o = LVL_W'(i);
      end
    end
  end

  assert_win_above_pil_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (win_lvl_o > pil_i));
  assert_win_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> pend_i[win_lvl_o]);
endmodule

// File: rtl/pil_trap_gate.sv
module pil_trap_gate #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned TT_W  = 9,
  parameter int unsigned TL_W  = 3,
  parameter logic [TT_W-1:0] TT_BASE = 9'h040
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             win_vld_i,
  input  logic [LVL_W-1:0] win_lvl_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [TT_W-1:0]  svc_tt_i,
  output logic             req_o,
  output logic [TT_W-1:0]  tt_o
);
  logic            req_q, req_n;
  logic [TT_W-1:0] tt_q, tt_n, code;
  logic            blocked;

  assign code    = TT_BASE | TT_W'(win_lvl_i);
  assign blocked = (tl_i != '0) && (svc_tt_i > code);

  always_comb begin
    req_n = req_q;
    tt_n  = tt_q;
    if (req_q) begin
      // drop outstanding request before re-evaluating
      req_n = 1'b0;
      tt_n  = '0;
    end
    if (en_i && win_vld_i && !blocked && (tt_n != code)) begin
      req_n = 1'b1;
      tt_n  = code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else begin
      req_q <= req_n;
      tt_q  <= tt_n;
    end
  end

  assign req_o = req_q;
  assign tt_o  = tt_q;

  assert_blocked_no_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_i && blocked) |=> !req_o);
  assert_base_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((tt_o & ~TT_W'(2**LVL_W - 1)) == (TT_BASE & ~TT_W'(2**LVL_W - 1))));
endmodule

// File: rtl/pil_sel_top.sv
module pil_sel_top #(
  parameter int unsigned TL_W      = 3,
  parameter int unsigned TIMER_LVL = 14,
  parameter logic [pil_sel_pkg::TT_W-1:0] TT_BASE = 9'h040
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:1] ext_irq_i,
  input  logic [15:0] soft_int_i,
  input  logic        tick_match_i,
  input  logic        stick_match_i,
  input  logic [3:0]  pil_i,
  input  logic        int_en_i,
  input  logic [TL_W-1:0] tl_i,
  input  logic [8:0]  svc_tt_i,
  output logic        irq_req_o,
  output logic [8:0]  irq_tt_o
);
  import pil_sel_pkg::*;

  pend_t pend;
  logic  win_vld;
  lvl_t  win_lvl;

  pil_pend_merge #(
    .NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL), .SOFT_MASK(NUM_LVL'(1))
  ) merge_i (
    .ext_irq_i(ext_irq_i), .soft_int_i(soft_int_i),
    .tick_hit_i(tick_match_i), .stick_hit_i(stick_match_i), .pend_o(pend)
  );

  pil_prio_scan #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) scan_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .pil_i(pil_i),
    .win_vld_o(win_vld), .win_lvl_o(win_lvl)
  );

  pil_trap_gate #(.LVL_W(LVL_W), .TT_W(TT_W), .TL_W(TL_W), .TT_BASE(TT_BASE)) gate_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(int_en_i),
    .win_vld_i(win_vld), .win_lvl_i(win_lvl), .tl_i(tl_i), .svc_tt_i(svc_tt_i),
    .req_o(irq_req_o), .tt_o(irq_tt_o)
  );

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |=> !irq_req_o);
  assert_idle_zero_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_tt_o == '0));
  assert_req_above_pil_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && $past(rst_ni)) |-> (irq_tt_o[3:0] > $past(pil_i)));
  assert_req_not_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && $past(rst_ni)) |-> !(($past(tl_i) != '0) && ($past(svc_tt_i) > irq_tt_o)));
  assert_timer_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tick_match_i || stick_match_i) && int_en_i && pil_i < 4'd14 && tl_i == '0) |=> irq_req_o);
endmodule

// File: tb/pil_sel_top_tb_top.sv
module pil_sel_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:1] ext_irq_i = '0;
  logic [15:0] soft_int_i = '0;
  logic        tick_match_i = 1'b0;
  logic        stick_match_i = 1'b0;
  logic [3:0]  pil_i = '0;
  logic        int_en_i = 1'b0;
  logic [2:0]  tl_i = '0;
  logic [8:0]  svc_tt_i = '0;
  logic        irq_req_o;
  logic [8:0]  irq_tt_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  pil_sel_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_irq_i(ext_irq_i), .soft_int_i(soft_int_i),
    .tick_match_i(tick_match_i), .stick_match_i(stick_match_i), .pil_i(pil_i),
    .int_en_i(int_en_i), .tl_i(tl_i), .svc_tt_i(svc_tt_i),
    .irq_req_o(irq_req_o), .irq_tt_o(irq_tt_o)
  );

  // expected code, 0 = no request
  function automatic logic [8:0] model();
    logic [15:0] p;
    p = {ext_irq_i, 1'b0} | (soft_int_i & 16'hFFFE);
    if (tick_match_i || stick_match_i) p[14] = 1'b1;
    if (!int_en_i) return 9'd0;
    for (int l = 15; l > int'(pil_i); l--) begin
      if (p[l]) begin
        if (tl_i != 3'd0 && svc_tt_i > 9'(9'h040 + l)) return 9'd0;
        return 9'(9'h040 + l);
      end
    end
    return 9'd0;
  endfunction

  task automatic cmp(input string tag, input logic [8:0] exp);
    checks++;
    if (irq_req_o !== (exp != 0) || irq_tt_o !== exp) begin
      failures++;
      $display("FAIL %s req=%0b tt=%03h expected req=%0b tt=%03h", tag,
               irq_req_o, irq_tt_o, exp != 0, exp);
    end
  endtask

  // inputs already set after a negedge; one edge later check
  task automatic step(input string tag);
    logic [8:0] e;
    e = model();
    @(posedge clk_i);
    @(negedge clk_i);
    cmp(tag, e);
  endtask

  task automatic idle();
    ext_irq_i = '0; soft_int_i = '0; tick_match_i = 0; stick_match_i = 0;
    pil_i = '0; int_en_i = 1; tl_i = '0; svc_tt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low with active stimulus
    ext_irq_i = 15'h7FFF; int_en_i = 1;
    repeat (3) @(negedge clk_i);
    cmp("R1 reset", 9'd0);
    rst_ni = 1'b1;
    idle();
    step("R1 after reset idle");

    // R2 R4 R5: every single external level against every pil
    for (int l = 1; l < 16; l++)
      for (int p = 0; p < 16; p++) begin
        idle(); ext_irq_i[l] = 1; pil_i = 4'(p);
        step("R2 R4 R5 ext sweep");
      end
    // R2: soft sweep, bit 0 ignored
    for (int l = 0; l < 16; l++)
      for (int p = 0; p < 16; p++) begin
        idle(); soft_int_i[l] = 1; pil_i = 4'(p);
        step("R2 soft sweep");
      end
    // R3: timer flags fold into level 14
    for (int t = 1; t < 4; t++)
      for (int p = 0; p < 16; p++) begin
        idle(); tick_match_i = t[0]; stick_match_i = t[1]; pil_i = 4'(p);
        step("R3 timer flag");
      end
    idle(); tick_match_i = 1; ext_irq_i[15] = 1; step("R3 R4 level 15 beats timer");
    idle(); stick_match_i = 1; soft_int_i[13] = 1; step("R3 R4 timer beats 13");

    // R6: suppression boundary
    for (int l = 1; l < 16; l++)
      for (int d = -1; d < 2; d++)
        for (int t = 0; t < 2; t++) begin
          idle(); ext_irq_i[l] = 1; tl_i = 3'(t * 3);
          svc_tt_i = 9'(9'h040 + l + d);
          step("R6 trap in service");
        end
    idle(); ext_irq_i[5] = 1; tl_i = 1; svc_tt_i = 9'h1FF; step("R6 large svc tt");

    // R7: disable then re-enable
    idle(); ext_irq_i = 15'h7FFF; step("R7 enabled before");
    int_en_i = 0; step("R7 disabled");
    step("R7 disabled hold");
    int_en_i = 1; step("R7 re-enabled");

    // R8: no change before the edge
    idle(); ext_irq_i[9] = 1; step("R8 setup");
    ext_irq_i[9] = 0; ext_irq_i[3] = 1;
    #1 cmp("R8 before edge", 9'h049);
    step("R8 after edge");

    // R9 and mixed patterns
    for (int n = 0; n < 3000; n++) begin
      ext_irq_i = 15'($urandom); soft_int_i = 16'($urandom);
      if (n % 4 == 0) begin ext_irq_i = '0; soft_int_i = 16'($urandom) & 16'h0001; end
      tick_match_i = ($urandom % 5) == 0; stick_match_i = ($urandom % 5) == 0;
      pil_i = 4'($urandom); int_en_i = ($urandom % 6) != 0;
      tl_i = 3'($urandom % 3); svc_tt_i = 9'(9'h040 + ($urandom % 20));
      step("R9 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule